// File: doc/BRIEF.md
# In-Order Completion Queue

This block records dispatched instructions in program order and releases them in that same order, even when execution units finish them out of order. It holds up to six entries in a circular store indexed by an oldest-entry pointer and an occupancy count. Each cycle it can accept up to two new entries and retire up to two old ones. Each entry carries an instruction ID, a flag marking it as a predicted branch, and a flag marking it as completion-serialized.

Execution units report completion by the queue slot number that the block hands back at dispatch. Each report may carry an exception. A branch-resolve port reports a branch's slot and whether it was mispredicted. The retire strobes tell the rename logic which results to commit. The exception request asks the vector logic to take a precise exception. The flush strobe tells the rest of the pipeline that younger work has been dropped.

Top module: `inorder_cq`

## Requirements
- R1: After reset the queue is empty: `ret_valid` is 00, `exc_req` and `flush` are 0, and a two-wide dispatch is accepted.
- R2: An accepted lane 0 is written to the slot shown on `disp_slot0`, which is the free position just past the youngest entry. Lane 1 is written to `disp_slot1`, which is one position further on (modulo 6) when lane 0 is also valid.
- R3: The queue holds 6 entries. A dispatch request is accepted whole or not at all: `disp_accept` is 00 when fewer slots are free than the number of lanes that would be taken.
- R4: Only the oldest entry can retire alone. An entry retires only once it has finished, and `ret_id0` is always the oldest entry's ID.
- R5: The second-oldest entry retires in the same cycle as the oldest (`ret_valid` = 11) only if both have finished, neither carries an exception, and neither is serialized.
- R6: When both dispatch lanes are valid and either is serialized, only lane 0 is accepted (`disp_accept` = 01).
- R7: A finish report for a serialized entry takes effect only while that entry is the oldest. Otherwise the report is ignored, so the entry does not retire after it.
- R8: A branch that has not yet resolved cannot retire, and neither can anything younger than it.
- R9: A mispredicted resolution of a live, unresolved branch raises `flush` in that cycle and refuses dispatch. It also drops every entry younger than the branch, so that the next free slot is the one just after the branch.
- R10: An exception recorded on an entry is acted on only when that entry is the oldest. Then `exc_req` rises with `exc_id` equal to its ID, `flush` rises, nothing retires, and the queue is empty in the next cycle.
- R11: A correct resolution marks the branch finished, so it and finished younger entries may retire in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 2 | Dispatch lane valid bits |
| disp_id0 | input | ID_W | Lane 0 instruction ID |
| disp_id1 | input | ID_W | Lane 1 instruction ID |
| disp_branch | input | 2 | Per-lane predicted-branch flag |
| disp_serial | input | 2 | Per-lane serialization flag |
| disp_accept | output | 2 | Lanes taken this cycle |
| disp_slot0 | output | PW | Slot assigned to lane 0 |
| disp_slot1 | output | PW | Slot assigned to lane 1 |
| fin_valid | input | 2 | Finish report valid per lane |
| fin_slot0 | input | PW | Slot finished by lane 0 |
| fin_slot1 | input | PW | Slot finished by lane 1 |
| fin_exc | input | 2 | Exception flag per finish lane |
| br_valid | input | 1 | Branch resolution valid |
| br_slot | input | PW | Slot of the resolved branch |
| br_mispredict | input | 1 | Resolution was a misprediction |
| ret_valid | output | 2 | Retire strobes, bit 0 oldest |
| ret_id0 | output | ID_W | ID retiring on strobe 0 |
| ret_id1 | output | ID_W | ID retiring on strobe 1 |
| exc_req | output | 1 | Precise exception request |
| exc_id | output | ID_W | ID of the faulting entry |
| flush | output | 1 | Younger work dropped this cycle |

## Verification
The accept mask, the assigned slots, the flush strobe and the exception request follow from the stored state and the inputs of the same cycle. The bench therefore samples them one time unit after the falling edge at which it drives the inputs. Finish reports, resolutions and dispatches change only the stored state, so their effect on the retire strobes and IDs shows one rising edge later, and that is the cycle in which the bench's expectations for them are set. A cycle-level queue model in the bench advances exactly at each rising edge. It supplies the expected values for every cycle of both the directed cases and the seeded random traffic.

// File: rtl/inorder_cq.sv
module inorder_cq #(
  parameter int DEPTH = 6,
  parameter int ID_W  = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NS   = 1 << PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      disp_valid,
  input  logic [ID_W-1:0] disp_id0,
  input  logic [ID_W-1:0] disp_id1,
  input  logic [1:0]      disp_branch,
  input  logic [1:0]      disp_serial,
  output logic [1:0]      disp_accept,
  output logic [PW-1:0]   disp_slot0,
  output logic [PW-1:0]   disp_slot1,
  input  logic [1:0]      fin_valid,
  input  logic [PW-1:0]   fin_slot0,
  input  logic [PW-1:0]   fin_slot1,
  input  logic [1:0]      fin_exc,
  input  logic            br_valid,
  input  logic [PW-1:0]   br_slot,
  input  logic            br_mispredict,
  output logic [1:0]      ret_valid,
  output logic [ID_W-1:0] ret_id0,
  output logic [ID_W-1:0] ret_id1,
  output logic            exc_req,
  output logic [ID_W-1:0] exc_id,
  output logic            flush
);

  logic [PW-1:0]   head;
  logic [CW-1:0]   cnt;
  logic [ID_W-1:0] ids [NS];
  logic [NS-1:0]   is_ser, unres, done, exc;
  logic [NS-1:0]   live;

  function automatic int age(input logic [PW-1:0] s, input logic [PW-1:0] h);
    return (int'(s) - int'(h) + DEPTH) % DEPTH;
  endfunction

  function automatic logic [PW-1:0] wrap(input int v);
    return PW'(v % DEPTH);
  endfunction

  always_comb begin
    live = '0;
    for (int i = 0; i < DEPTH; i++)
      live[i] = age(PW'(i), head) < int'(cnt);
  end

  logic [PW-1:0] tail, nxt;
  logic          h_ok, s_ok, mis;
  logic [1:0]    want;
  int            nret, nacc, need;

  assign tail = wrap(int'(head) + int'(cnt));
  assign nxt  = wrap(int'(head) + 1);

  assign exc_req = (cnt != 0) && done[head] && exc[head];
  assign exc_id  = ids[head];
  assign h_ok    = (cnt != 0) && done[head] && !exc[head] && !unres[head];
  assign s_ok    = h_ok && (cnt > 1) && done[nxt] && !exc[nxt] && !unres[nxt]
                   && !is_ser[nxt] && !is_ser[head];
  assign ret_valid = {s_ok, h_ok};
  assign ret_id0   = ids[head];
  assign ret_id1   = ids[nxt];

  assign mis   = br_valid && br_mispredict && live[br_slot] && unres[br_slot];
  assign flush = exc_req || mis;

  assign want = (disp_valid == 2'b11 && |(disp_serial & disp_valid)) ? 2'b01 : disp_valid;
  assign need = int'(want[0]) + int'(want[1]);
  assign disp_accept = (flush || (DEPTH - int'(cnt)) < need) ? 2'b00 : want;
  assign disp_slot0  = tail;
  assign disp_slot1  = wrap(int'(tail) + int'(disp_valid[0]));
  assign nret = int'(h_ok) + int'(s_ok);
  assign nacc = int'(disp_accept[0]) + int'(disp_accept[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      cnt    <= '0;
      is_ser <= '0;
      unres  <= '0;
      done   <= '0;
      exc    <= '0;
    end else if (exc_req) begin
      cnt <= '0;
    end else begin
      head <= wrap(int'(head) + nret);
      if (mis) cnt <= CW'(age(br_slot, head) + 1 - nret);
      else     cnt <= CW'(int'(cnt) - nret + nacc);
      if (fin_valid[0] && live[fin_slot0] && (!is_ser[fin_slot0] || fin_slot0 == head)) begin
        done[fin_slot0] <= 1'b1;
        exc[fin_slot0]  <= fin_exc[0];
      end
      if (fin_valid[1] && live[fin_slot1] && (!is_ser[fin_slot1] || fin_slot1 == head)) begin
        done[fin_slot1] <= 1'b1;
        exc[fin_slot1]  <= fin_exc[1];
      end
      if (br_valid && live[br_slot] && unres[br_slot]) begin
        unres[br_slot] <= 1'b0;
        done[br_slot]  <= 1'b1;
      end
      if (disp_accept[0]) begin
        ids[tail]    <= disp_id0;
        is_ser[tail] <= disp_serial[0];
        unres[tail]  <= disp_branch[0];
        done[tail]   <= 1'b0;
        exc[tail]    <= 1'b0;
      end
      if (disp_accept[1]) begin
        ids[disp_slot1]    <= disp_id1;
        is_ser[disp_slot1] <= disp_serial[1];
        unres[disp_slot1]  <= disp_branch[1];
        done[disp_slot1]   <= 1'b0;
        exc[disp_slot1]    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/inorder_cq_chk.sv
module inorder_cq_chk #(
  parameter int DEPTH = 6,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    disp_valid,
  input logic [1:0]    disp_serial,
  input logic [1:0]    disp_accept,
  input logic [1:0]    ret_valid,
  input logic          exc_req,
  input logic          flush,
  input logic [CW-1:0] cnt
);

  // R3
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  // R3
  fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_accept) <= DEPTH - int'(cnt));

  // R4
  ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[1] |-> ret_valid[0]);

  // R6
  ser_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid == 2'b11 && |disp_serial) |-> !disp_accept[1]);

  // R9
  flush_no_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> disp_accept == 2'b00);

  // R10
  exc_no_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ret_valid == 2'b00);

  // R10
  exc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> cnt == '0);

endmodule

bind inorder_cq inorder_cq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_serial(disp_serial),
  .disp_accept(disp_accept), .ret_valid(ret_valid), .exc_req(exc_req),
  .flush(flush), .cnt(cnt)
);

// File: tb/inorder_cq_tb.sv
`timescale 1ns/1ps
module inorder_cq_tb;
  localparam int D = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] dv = 0, dbr = 0, dser = 0, fv = 0, fx = 0;
  logic [7:0] id0 = 0, id1 = 0;
  logic [2:0] fs0 = 0, fs1 = 0, bs = 0;
  logic bv = 0, bm = 0;
  logic [1:0] acc, rv;
  logic [2:0] s0, s1;
  logic [7:0] rid0, rid1, eid;
  logic exq, fl;

  always #2.5 clk = ~clk;

  inorder_cq u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_id0(id0), .disp_id1(id1),
    .disp_branch(dbr), .disp_serial(dser), .disp_accept(acc), .disp_slot0(s0),
    .disp_slot1(s1), .fin_valid(fv), .fin_slot0(fs0), .fin_slot1(fs1), .fin_exc(fx),
    .br_valid(bv), .br_slot(bs), .br_mispredict(bm), .ret_valid(rv), .ret_id0(rid0),
    .ret_id1(rid1), .exc_req(exq), .exc_id(eid), .flush(fl)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  int mh, mc;
  int mid[D], mser[D], munr[D], mdone[D], mexc[D];
  int e_acc, e_rv, e_exc, e_fl, e_s0, e_s1, nret, mis;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int mage(input int s);
    return (s - mh + D) % D;
  endfunction

  function automatic bit mlive(input int s);
    return s < D && mage(s) < mc;
  endfunction

  task automatic model_eval();
    int h, n, want, need;
    h = mh; n = (mh + 1) % D;
    e_exc = (mc > 0 && mdone[h] != 0 && mexc[h] != 0);
    e_rv = 0;
    if (mc > 0 && mdone[h] != 0 && mexc[h] == 0 && munr[h] == 0) begin
      e_rv = 1;
      if (mc > 1 && mdone[n] != 0 && mexc[n] == 0 && munr[n] == 0 && mser[n] == 0 && mser[h] == 0)
        e_rv = 3;
    end
    nret = (e_rv == 3) ? 2 : e_rv;
    mis = bv && bm && mlive(int'(bs)) && munr[bs] != 0;
    e_fl = e_exc | mis;
    want = (dv == 2'b11 && (dser != 0)) ? 1 : int'(dv);
    need = (want & 1) + (want >> 1);
    e_acc = (e_fl != 0 || D - mc < need) ? 0 : want;
    e_s0 = (mh + mc) % D;
    e_s1 = (e_s0 + int'(dv[0])) % D;
  endtask

  task automatic model_update();
    int t1, nacc, nc;
    if (e_exc != 0) begin
      mc = 0;
      return;
    end
    if (fv[0] && mlive(int'(fs0)) && (mser[fs0] == 0 || int'(fs0) == mh)) begin
      mdone[fs0] = 1; mexc[fs0] = int'(fx[0]);
    end
    if (fv[1] && mlive(int'(fs1)) && (mser[fs1] == 0 || int'(fs1) == mh)) begin
      mdone[fs1] = 1; mexc[fs1] = int'(fx[1]);
    end
    if (bv && mlive(int'(bs)) && munr[bs] != 0) begin
      munr[bs] = 0; mdone[bs] = 1;
    end
    if (e_acc & 1) begin
      mid[e_s0] = int'(id0); mser[e_s0] = int'(dser[0]); munr[e_s0] = int'(dbr[0]);
      mdone[e_s0] = 0; mexc[e_s0] = 0;
    end
    if (e_acc & 2) begin
      t1 = e_s1;
      mid[t1] = int'(id1); mser[t1] = int'(dser[1]); munr[t1] = int'(dbr[1]);
      mdone[t1] = 0; mexc[t1] = 0;
    end
    nacc = (e_acc & 1) + (e_acc >> 1);
    nc = mis ? mage(int'(bs)) + 1 - nret : mc - nret + nacc;
    mh = (mh + nret) % D;
    mc = nc;
  endtask

  task automatic settle();
    #1;
    model_eval();
    chk(int'(acc) == e_acc, "R3", int'(acc), e_acc);
    chk(int'(s0) == e_s0 && int'(s1) == e_s1, "R2", int'(s0), e_s0);
    chk(int'(rv) == e_rv, "R5", int'(rv), e_rv);
    if (e_rv != 0) chk(int'(rid0) == mid[mh], "R4", int'(rid0), mid[mh]);
    if (e_rv == 3) chk(int'(rid1) == mid[(mh + 1) % D], "R4", int'(rid1), mid[(mh + 1) % D]);
    chk(int'(exq) == e_exc, "R10", int'(exq), e_exc);
    if (e_exc != 0) chk(int'(eid) == mid[mh], "R10", int'(eid), mid[mh]);
    chk(int'(fl) == e_fl, "R9", int'(fl), e_fl);
  endtask

  task automatic advance();
    @(posedge clk);
    model_update();
    @(negedge clk);
    dv = 0; dbr = 0; dser = 0; fv = 0; fx = 0; bv = 0; bm = 0;
  endtask

  task automatic step();
    settle();
    advance();
  endtask

  task automatic do_reset();
    rst_n = 0;
    dv = 0; dbr = 0; dser = 0; fv = 0; fx = 0; bv = 0; bm = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mh = 0; mc = 0;
    for (int i = 0; i < D; i++) begin
      mser[i] = 0; munr[i] = 0; mdone[i] = 0; mexc[i] = 0; mid[i] = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R1 empty after reset
    dv = 2'b11; id0 = 10; id1 = 11; settle();
    chk(rv == 2'b00 && !exq && !fl, "R1", int'(rv), 0);
    chk(acc == 2'b11, "R1", int'(acc), 3);
    chk(s0 == 0 && s1 == 1, "R2", int'(s0), 0);
    advance();
    dv = 2'b11; id0 = 12; id1 = 13; step();
    dv = 2'b11; id0 = 14; id1 = 15; step();
    // R3 full queue refuses a single-lane request
    dv = 2'b01; id0 = 16; settle();
    chk(acc == 2'b00, "R3", int'(acc), 0);
    advance();
    // R4 younger finished, oldest not: nothing retires
    fv = 2'b01; fs0 = 1; step();
    settle(); chk(rv == 2'b00, "R4", int'(rv), 0); advance();
    fv = 2'b11; fs0 = 0; fs1 = 2; step();
    // R5 two-wide retire
    settle();
    chk(rv == 2'b11 && rid0 == 10 && rid1 == 11, "R5", int'(rv), 3);
    advance();

    do_reset();
    // R6 serialized pair dispatches one lane
    dv = 2'b11; dser = 2'b10; id0 = 20; id1 = 99; settle();
    chk(acc == 2'b01, "R6", int'(acc), 1);
    advance();
    dv = 2'b01; dser = 2'b01; id0 = 21; step();
    // R7 finish of non-oldest serialized entry ignored
    fv = 2'b01; fs0 = 1; step();
    fv = 2'b01; fs0 = 0; step();
    settle(); chk(rv == 2'b01 && rid0 == 20, "R7", int'(rv), 1); advance();
    fv = 2'b01; fs0 = 1; settle(); chk(rv == 2'b00, "R7", int'(rv), 0); advance();
    settle(); chk(rv == 2'b01 && rid0 == 21, "R7", int'(rid0), 21); advance();

    do_reset();
    dv = 2'b11; dbr = 2'b01; id0 = 30; id1 = 31; step();
    fv = 2'b01; fs0 = 1; step();
    // R8 unresolved branch holds itself and younger entries
    settle(); chk(rv == 2'b00, "R8", int'(rv), 0); advance();
    bv = 1; bs = 0; bm = 0; step();
    // R11 correct resolution lets both go
    settle(); chk(rv == 2'b11, "R11", int'(rv), 3); advance();

    do_reset();
    dv = 2'b11; dbr = 2'b01; id0 = 40; id1 = 41; step();
    dv = 2'b11; id0 = 42; id1 = 43; step();
    // R9 mispredict flushes younger entries
    bv = 1; bs = 0; bm = 1; dv = 2'b01; id0 = 44; settle();
    chk(fl == 1'b1 && acc == 2'b00, "R9", int'(fl), 1);
    advance();
    settle(); chk(rv == 2'b01 && rid0 == 40, "R9", int'(rv), 1); advance();
    dv = 2'b01; id0 = 45; settle(); chk(s0 == 1, "R9", int'(s0), 1); advance();

    do_reset();
    dv = 2'b11; id0 = 50; id1 = 51; step();
    fv = 2'b11; fs0 = 1; fx = 2'b01; fs1 = 0; step();
    // R10 exception waits for oldest position
    settle(); chk(rv == 2'b01 && !exq, "R10", int'(exq), 0); advance();
    settle();
    chk(exq && eid == 51 && rv == 2'b00 && fl, "R10", int'(eid), 51);
    advance();
    dv = 2'b01; id0 = 52; settle();
    chk(!exq && rv == 2'b00 && s0 == 1, "R10", int'(exq), 0);
    advance();

    do_reset();
    for (int c = 0; c < 4000; c++) begin
      dv  = 2'($urandom % 4);
      id0 = 8'($urandom); id1 = 8'($urandom);
      dbr = {($urandom % 4) == 0, ($urandom % 4) == 0};
      dser = {($urandom % 8) == 0, ($urandom % 8) == 0};
      fv  = 2'($urandom % 4);
      fs0 = 3'($urandom % 6); fs1 = 3'($urandom % 6);
      fx  = {($urandom % 32) == 0, ($urandom % 32) == 0};
      bv  = ($urandom % 4) == 0;
      bs  = 3'($urandom % 6);
      bm  = ($urandom % 3) == 0;
      step();
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule